// File: doc/BRIEF.md
# Posted Interrupt Controller with Software Posting

This block gathers eight interrupt sources into a posted register that keeps each request until software or the dispatch unit clears it. Six sources are single-cycle pulse inputs. The two general-purpose port sources are level inputs, and they post only on a rising edge. A mask register decides which posted sources may reach the CPU. Of the posted sources that are enabled, the one with the lowest bit number is offered to the dispatch unit as a request line plus an 8-bit table vector. An acknowledge from the dispatch unit clears that posted bit.

Software uses a byte-wide register port with a combinational read path.

| Select | Register | Contents |
|---|---|---|
| 0 | posted | one bit per source |
| 1 | mask | one enable bit per source |
| 2 | control | bit 7 is the software-post enable; bits 6..0 read 0 |
| 3 | none | reads 0 |

Writing 0 to a posted bit clears it. Writing 1 to a posted bit posts that source, but only while the software-post enable is 1.

Source bit assignment:

| Bit | Source |
|---|---|
| 0 | supply monitor (power-on reset / low voltage) |
| 1 | external line A |
| 2 | serial transmit |
| 3 | serial receive |
| 4 | port 0, edge detected |
| 5 | external line B |
| 6 | sleep timer |
| 7 | port 1, edge detected |

A small dispatch state machine drives the request. It has two states:

- `ST_IDLE`: no request is offered.
- `ST_PRESENT`: a request is offered and its vector is held.

It has three transitions:

- grant (`ST_IDLE` to `ST_PRESENT`): at least one source is both posted and enabled. The winning index is latched.
- retire (`ST_PRESENT` to `ST_IDLE`): an acknowledge arrives while the request is high.
- withdraw (`ST_PRESENT` to `ST_IDLE`): the latched source stops being posted or enabled.

Top module: `irq_post_ctrl`

## Requirements
- R1: After reset the posted, mask and control registers read 0x00 and `irq_req` is 0.
- R2: A pulse source (bits 0, 1, 2, 3, 5, 6 of `src_in`) that is high at a rising clock edge sets its posted bit at that edge. The bit is readable at select 0 right after that edge.
- R3: Port sources (bits 4 and 7) post only on a low-to-high change of the input. A level that stays high does not post the bit again after software clears it.
- R4: A write to select 0 clears every posted bit whose write-data bit is 0. While control bit 7 is 0, write-data bits that are 1 leave their posted bits unchanged.
- R5: While control bit 7 is 1, a write to select 0 sets every posted bit whose write-data bit is 1. Control bit 7 reads back as written.
- R6: A posted source whose mask bit is 0 stays posted and raises no request. One clock edge after its mask bit is written to 1, `irq_req` goes high.
- R7: The vector for source n is 0x04 + 4*n. When several enabled sources are posted, the lowest bit number is offered first.
- R8: `irq_ack` asserted while `irq_req` is high clears the posted bit of the offered source at that edge, and `irq_req` is low for the following cycle. `irq_ack` asserted while `irq_req` is low has no effect.
- R9: A source event in the same cycle as a software write of 0 to that bit leaves the bit set.
- R10: While a request is offered, the vector holds even if a higher-priority source posts. If software clears or masks the offered source, `irq_req` drops right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rst_n | input | 1 | active-low synchronous reset |
| src_in | input | 8 | interrupt sources: pulses, plus port levels on bits 4 and 7 |
| reg_sel | input | 2 | register select: 0 posted, 1 mask, 2 control |
| reg_wr | input | 1 | write strobe for the selected register |
| reg_wdata | input | 8 | write data |
| reg_rdata | output | 8 | read data of the selected register (combinational) |
| irq_ack | input | 1 | dispatch acknowledge of the offered vector |
| irq_req | output | 1 | interrupt request to the dispatch unit |
| irq_vec | output | 8 | table vector of the offered source, 0 when no request |

## Verification
The hardest case to reach from the ports is a source event that lands in the same cycle as a software write that clears the same bit. The bench reaches it by raising a pulse source and the write strobe together before a single edge, then reading the posted register back. A second hard case is withdrawal in the middle of a presentation. The bench reaches it by posting a source, unmasking it so the machine moves to `ST_PRESENT`, and then writing 0 to that posted bit. A third is holding a port input high across a software clear, which shows that a steady level does not post the bit again.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } disp_state_e;

    typedef enum logic [1:0] {
        SEL_POSTED = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
    parameter int          N_SRC     = 8,
    parameter logic [N_SRC-1:0] EDGE_MASK = 8'h90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    output logic [N_SRC-1:0] evt
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (EDGE_MASK[i]) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= src_in[i];
            end
            assign evt[i] = src_in[i] & ~prev_q;
        end else begin : g_pulse
            assign evt[i] = src_in[i];
        end
    end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_pkg::*;
#(
    parameter int N_SRC    = 8,
    parameter int SWEN_BIT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt,
    input  logic [N_SRC-1:0] ack_clr,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic [N_SRC-1:0] reg_wdata,
    output logic [N_SRC-1:0] reg_rdata,
    output logic [N_SRC-1:0] posted_q,
    output logic [N_SRC-1:0] mask_q,
    output logic             swen_q
);
    logic             wr_post;
    logic [N_SRC-1:0] set_v;
    logic [N_SRC-1:0] clr_v;
    logic [N_SRC-1:0] ctrl_rd;

    assign wr_post = reg_wr && (reg_sel == SEL_POSTED);

    always_comb begin
        set_v = evt | (wr_post && swen_q ? reg_wdata : '0);
        clr_v = ack_clr | (wr_post ? ~reg_wdata : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            posted_q <= '0;
            mask_q   <= '0;
            swen_q   <= 1'b0;
        end else begin
            posted_q <= set_v | (posted_q & ~clr_v);
            if (reg_wr && reg_sel == SEL_MASK) mask_q <= reg_wdata;
            if (reg_wr && reg_sel == SEL_CTRL) swen_q <= reg_wdata[SWEN_BIT];
        end
    end

    always_comb begin
        ctrl_rd           = '0;
        ctrl_rd[SWEN_BIT] = swen_q;
        unique case (reg_sel)
            SEL_POSTED: reg_rdata = posted_q;
            SEL_MASK:   reg_rdata = mask_q;
            SEL_CTRL:   reg_rdata = ctrl_rd;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int N_SRC = 8,
    localparam int IDXW = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0] active,
    output logic             any,
    output logic [IDXW-1:0]  idx
);
    always_comb begin
        any = |active;
        idx = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (active[i]) idx = IDXW'(i);
        end
    end
endmodule

// File: rtl/irq_dispatch_fsm.sv
module irq_dispatch_fsm
    import irq_pkg::*;
#(
    parameter int          N_SRC    = 8,
    parameter logic [7:0]  VEC_BASE = 8'h04,
    parameter int          VEC_STEP = 4,
    localparam int IDXW = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] active,
    input  logic             any,
    input  logic [IDXW-1:0]  win_idx,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [7:0]       irq_vec,
    output logic [N_SRC-1:0] ack_clr
);
    disp_state_e     state_q, state_d;
    logic [IDXW-1:0] idx_q, idx_d;
    logic            still_live;

    assign still_live = active[idx_q];

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any) begin              // grant
                    state_d = ST_PRESENT;
                    idx_d   = win_idx;
                end
            end
            ST_PRESENT: begin
                if (!still_live)            // withdraw
                    state_d = ST_IDLE;
                else if (irq_ack)           // retire
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        irq_req = 1'b0;
        irq_vec = 8'h00;
        ack_clr = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PRESENT: begin
                irq_req = still_live;
                if (still_live) begin
                    irq_vec = VEC_BASE + 8'(idx_q) * 8'(VEC_STEP);
                    if (irq_ack) ack_clr[idx_q] = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_post_ctrl.sv
module irq_post_ctrl #(
    parameter int          N_SRC     = 8,
    parameter logic [7:0]  EDGE_MASK = 8'h90,
    parameter logic [7:0]  VEC_BASE  = 8'h04,
    parameter int          VEC_STEP  = 4,
    parameter int          SWEN_BIT  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_in,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic [N_SRC-1:0] reg_wdata,
    output logic [N_SRC-1:0] reg_rdata,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [7:0]       irq_vec
);
    localparam int IDXW = $clog2(N_SRC);

    logic [N_SRC-1:0] hw_evt;
    logic [N_SRC-1:0] posted_q;
    logic [N_SRC-1:0] mask_q;
    logic             swen_q;
    logic [N_SRC-1:0] active;
    logic             any;
    logic [IDXW-1:0]  win_idx;
    logic [N_SRC-1:0] ack_clr;

    assign active = posted_q & mask_q;

    irq_src_detect #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK[N_SRC-1:0])) u_det (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .evt(hw_evt)
    );

    irq_regfile #(.N_SRC(N_SRC), .SWEN_BIT(SWEN_BIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .evt(hw_evt), .ack_clr(ack_clr),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .posted_q(posted_q), .mask_q(mask_q),
        .swen_q(swen_q)
    );

    irq_prio_enc #(.N_SRC(N_SRC)) u_prio (
        .active(active), .any(any), .idx(win_idx)
    );

    irq_dispatch_fsm #(.N_SRC(N_SRC), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_fsm (
        .clk(clk), .rst_n(rst_n), .active(active), .any(any),
        .win_idx(win_idx), .irq_ack(irq_ack), .irq_req(irq_req),
        .irq_vec(irq_vec), .ack_clr(ack_clr)
    );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int         N_SRC    = 8,
    parameter logic [7:0] VEC_BASE = 8'h04,
    parameter int         VEC_STEP = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_req,
    input logic             irq_ack,
    input logic [7:0]       irq_vec,
    input logic [N_SRC-1:0] posted,
    input logic [N_SRC-1:0] mask,
    input logic [N_SRC-1:0] evt,
    input logic             reg_wr,
    input logic [1:0]       reg_sel,
    input logic             swen
);
    localparam logic [7:0] VEC_TOP = VEC_BASE + 8'(VEC_STEP * (N_SRC - 1));

    a_r7_vec_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec >= VEC_BASE && irq_vec <= VEC_TOP &&
                     ((irq_vec - VEC_BASE) % 8'(VEC_STEP)) == 8'h00));

    a_r10_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && $past(irq_req) && !$past(irq_ack)) |-> $stable(irq_vec));

    a_r8_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req);

    a_r6_req_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((posted & mask) != '0));

    a_r4_no_sw_post_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0 && !swen && evt == '0) |=>
            ((posted & ~$past(posted)) == '0));

    a_r9_event_always_posts: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((posted & $past(evt)) == $past(evt)));
endmodule

bind irq_post_ctrl irq_ctrl_chk #(.N_SRC(N_SRC), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
    .irq_vec(irq_vec), .posted(posted_q), .mask(mask_q), .evt(hw_evt),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .swen(swen_q)
);

// File: tb/tb_irq_post_ctrl.sv
`timescale 1ns/100ps
module tb_irq_post_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_in = '0;
    logic [1:0] reg_sel = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic [7:0] irq_vec;

    logic [7:0] gpio_lvl = '0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        int         kind;   // 0 read data, 1 request, 2 vector
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];
    event  sample_ev;

    always #2.5 clk = ~clk;

    irq_post_ctrl dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .reg_sel(reg_sel),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(sample_ev);
            #0.2;
            while (sb.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = reg_rdata;
                    1:       act = {7'd0, irq_req};
                    default: act = irq_vec;
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(int kind, logic [1:0] sel, logic [7:0] exp, string tag);
        item_t it;
        if (kind == 0) reg_sel = sel;
        it.kind = kind; it.exp = exp; it.tag = tag;
        sb.push_back(it);
        -> sample_ev;
        #0.4;
    endtask

    task automatic bus_wr(logic [1:0] sel, logic [7:0] data);
        reg_sel = sel; reg_wdata = data; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic pulse(logic [7:0] bits);
        src_in = bits | gpio_lvl;
        tick();
        src_in = gpio_lvl;
    endtask

    task automatic ack_once();
        irq_ack = 1'b1;
        tick();
        irq_ack = 1'b0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset values
        push(0, 2'd0, 8'h00, "R1 posted");
        push(0, 2'd1, 8'h00, "R1 mask");
        push(0, 2'd2, 8'h00, "R1 ctrl");
        push(1, 2'd0, 8'h00, "R1 req");

        // R2 pulse source, masked so no request (R6)
        pulse(8'h02);
        push(0, 2'd0, 8'h02, "R2 posted bit1");
        tick();
        push(1, 2'd0, 8'h00, "R6 masked no req");
        bus_wr(2'd1, 8'h02);
        push(1, 2'd0, 8'h00, "R6 req one edge after mask");
        tick();
        push(1, 2'd0, 8'h01, "R6 req after unmask");
        push(2, 2'd0, 8'h08, "R7 vector bit1");

        // R10 higher priority arrives while presenting
        bus_wr(2'd1, 8'hFF);
        pulse(8'h21);
        push(0, 2'd0, 8'h23, "R2 posted bits 0,1,5");
        push(2, 2'd0, 8'h08, "R10 vector held");

        // R8 acknowledge sequence, R7 priority
        ack_once();
        push(0, 2'd0, 8'h21, "R8 ack cleared bit1");
        push(1, 2'd0, 8'h00, "R8 req low after ack");
        tick();
        push(2, 2'd0, 8'h04, "R7 lowest bit first");
        ack_once();
        tick();
        push(2, 2'd0, 8'h18, "R7 vector bit5");
        ack_once();
        push(0, 2'd0, 8'h00, "R8 all serviced");
        tick();
        push(1, 2'd0, 8'h00, "R8 idle after last ack");

        // R3 edge-detected port sources
        bus_wr(2'd1, 8'h00);
        gpio_lvl = 8'h10; src_in = gpio_lvl;
        tick();
        push(0, 2'd0, 8'h10, "R3 port0 rising edge");
        tick(); tick();
        bus_wr(2'd0, 8'h00);
        tick();
        push(0, 2'd0, 8'h00, "R3 held level no repost");
        gpio_lvl = 8'h00; src_in = gpio_lvl;
        tick();
        gpio_lvl = 8'h90; src_in = gpio_lvl;
        tick();
        push(0, 2'd0, 8'h90, "R3 both ports edge");

        // R4 write 1 ignored without enable, write 0 clears
        bus_wr(2'd0, 8'hFF);
        push(0, 2'd0, 8'h90, "R4 write1 no enable");
        bus_wr(2'd0, 8'h10);
        push(0, 2'd0, 8'h10, "R4 write0 clears bit7");

        // R5 software posting
        bus_wr(2'd2, 8'h80);
        push(0, 2'd2, 8'h80, "R5 ctrl readback");
        bus_wr(2'd0, 8'h41);
        push(0, 2'd0, 8'h41, "R5 sw post");

        // R9 event vs clear in same cycle
        src_in = 8'h04 | gpio_lvl;
        reg_sel = 2'd0; reg_wdata = 8'h40; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; src_in = gpio_lvl;
        push(0, 2'd0, 8'h44, "R9 event beats clear");

        // R10 withdraw on software clear
        bus_wr(2'd1, 8'h40);
        tick();
        push(1, 2'd0, 8'h01, "R10 req bit6");
        push(2, 2'd0, 8'h1C, "R7 vector bit6");
        bus_wr(2'd0, 8'h04);
        push(1, 2'd0, 8'h00, "R10 withdraw on clear");
        push(2, 2'd0, 8'h00, "R10 vector zero");

        // R8 ack without request ignored
        ack_once();
        push(0, 2'd0, 8'h04, "R8 stray ack ignored");
        tick();

        finished = 1'b1;
        summary();
    end
endmodule